// File: doc/BRIEF.md
# GPIO Edge-Event Interrupt Controller

This block watches eight general-purpose input lines for configurable edges and drives an active-low interrupt request. Each pin is brought into the clock domain through a two-flop synchroniser. It then passes a per-line polarity inversion, and its edges are found by comparing the current value with the value one clock earlier. Every line carries a 2-bit edge code that selects no edge, rising, falling or both.

Two sticky registers are linked. The event status register records a configured edge on any line, masked or not. The interrupt source register records only lines whose mask bit is clear. A write of one to a bit in either register clears that bit in both. Rewriting a line's edge code to a different value clears the line's bits in both registers. A two-state machine (IRQ_IDLE, IRQ_PENDING) holds the interrupt output. It moves IRQ_IDLE to IRQ_PENDING when the next interrupt source value has any bit set. It moves IRQ_PENDING to IRQ_IDLE when the next value is all zero. Otherwise it stays where it is. The output is low only in IRQ_PENDING.

A simple register bus (address, write data, write enable, combinational read data) reaches the registers. The address map is 0 line data (read only), 1 polarity, 2 mask, 3 upper sense, 4 lower sense, 5 interrupt source, 6 event status. Any other address reads as zero.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset the mask reads 0xFF; polarity, both sense registers, interrupt source and event status read 0x00; irq_n is high.
- R2: Edge code per line: 00 none, 01 rising, 10 falling, 11 both. The upper sense register (address 3) holds line 4+k in bits [2k+1:2k], and the lower register (address 4) holds line k in bits [2k+1:2k], for k = 0..3. A matching edge sets the line's event status bit (address 6, bit = line) whatever the mask.
- R3: A matching edge sets the interrupt source bit (address 5, bit = line) only when the line's mask bit is 0; a mask bit of 1 leaves the source bit clear.
- R4: irq_n is low exactly while at least one interrupt source bit is set, and it goes high in the cycle the last bit clears.
- R5: Writing 1 to an interrupt source bit clears that bit and the same event status bit; bits written 0 are untouched.
- R6: Writing 1 to an event status bit clears that bit and the same interrupt source bit.
- R7: Writing a sense register clears both sticky bits of each line whose code changes. A line whose code is rewritten with its present value keeps its bits.
- R8: A polarity bit of 1 inverts the line before the data read (address 0) and the edge logic, so a pin rise is seen as a fall. A polarity change itself appears as an edge.
- R9: An edge at a pin sets status, source and irq_n on the third rising clock edge after the pin changes, and not before.
- R10: If an edge and a write-one clear reach the same bit at the same clock edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous input lines |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A pin change reaches the synchronised value after two rising edges, so the line data read is due then. Status, source and irq_n are due on the third edge, one register later. The bench drives pins and bus fields on falling edges and samples on falling edges. It reads status once after two edges, where it must still be clear, and again after the third edge, where it must hold the expected value. Register writes take effect on the single rising edge under the write strobe, and their effect on status, source and irq_n is checked at the next falling edge. The collision case is timed so that the clear write lands on the same rising edge as the third edge after the pin toggle.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_code_e;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

    localparam int          ADDR_W        = 3;
    localparam logic [2:0]  ADDR_DATA     = 3'd0;
    localparam logic [2:0]  ADDR_POL      = 3'd1;
    localparam logic [2:0]  ADDR_MASK     = 3'd2;
    localparam logic [2:0]  ADDR_SENSE_HI = 3'd3;
    localparam logic [2:0]  ADDR_SENSE_LO = 3'd4;
    localparam logic [2:0]  ADDR_SRC      = 3'd5;
    localparam logic [2:0]  ADDR_STS      = 3'd6;

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge
    import gpio_evt_pkg::*;
(
    input  logic [1:0] code_i,
    input  logic       cur_i,
    input  logic       prev_i,
    output logic       hit_o
);
    logic rise, fall;

    assign rise = cur_i & ~prev_i;
    assign fall = ~cur_i & prev_i;

    always_comb begin
        unique case (edge_code_e'(code_i))
            EDGE_NONE: hit_o = 1'b0;
            EDGE_RISE: hit_o = rise;
            EDGE_FALL: hit_o = fall;
            EDGE_BOTH: hit_o = rise | fall;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_evt_irq_fsm.sv
module gpio_evt_irq_fsm
    import gpio_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_n
);
    irq_state_e state_q, state_nx;

    always_comb begin
        unique case (state_q)
            IRQ_IDLE:    state_nx = pending_i ? IRQ_PENDING : IRQ_IDLE;
            IRQ_PENDING: state_nx = pending_i ? IRQ_PENDING : IRQ_IDLE;
            default:     state_nx = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        irq_n = (state_q != IRQ_PENDING);
    end
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
    import gpio_evt_pkg::*;
#(
    parameter int LINES       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  pin_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    output logic              irq_n
);
    localparam int HALF = LINES / 2;

    logic [LINES-1:0]      sync_val, view, prev_q;
    logic [LINES-1:0]      pol_q, mask_q, src_q, sts_q;
    logic [LINES-1:0]      src_nx, sts_nx, hit, code_chg, w1c;
    logic [LINES-1:0][1:0] sense_q, sense_nx;
    logic                  wr_pol, wr_mask, wr_hi, wr_lo, wr_src, wr_sts;

    gpio_evt_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_val)
    );

    assign view = sync_val ^ pol_q;

    assign wr_pol  = bus_we && (bus_addr == ADDR_POL);
    assign wr_mask = bus_we && (bus_addr == ADDR_MASK);
    assign wr_hi   = bus_we && (bus_addr == ADDR_SENSE_HI);
    assign wr_lo   = bus_we && (bus_addr == ADDR_SENSE_LO);
    assign wr_src  = bus_we && (bus_addr == ADDR_SRC);
    assign wr_sts  = bus_we && (bus_addr == ADDR_STS);

    always_comb begin
        sense_nx = sense_q;
        if (wr_hi) sense_nx[LINES-1:HALF] = bus_wdata;
        if (wr_lo) sense_nx[HALF-1:0]     = bus_wdata;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        gpio_evt_edge u_edge (
            .code_i (sense_q[i]),
            .cur_i  (view[i]),
            .prev_i (prev_q[i]),
            .hit_o  (hit[i])
        );
        assign code_chg[i] = (sense_nx[i] != sense_q[i]);
    end

    assign w1c    = (wr_src || wr_sts) ? bus_wdata : '0;
    // new edge dominates a write-one clear; a code change dominates both
    assign sts_nx = ((sts_q & ~w1c) | hit) & ~code_chg;
    assign src_nx = ((src_q & ~w1c) | (hit & ~mask_q)) & ~code_chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q   <= '0;
            mask_q  <= '1;
            sense_q <= '0;
            src_q   <= '0;
            sts_q   <= '0;
            prev_q  <= '0;
        end else begin
            if (wr_pol)  pol_q  <= bus_wdata;
            if (wr_mask) mask_q <= bus_wdata;
            sense_q <= sense_nx;
            src_q   <= src_nx;
            sts_q   <= sts_nx;
            prev_q  <= view;
        end
    end

    gpio_evt_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (|src_nx),
        .irq_n     (irq_n)
    );

    always_comb begin
        case (bus_addr)
            ADDR_DATA:     bus_rdata = view;
            ADDR_POL:      bus_rdata = pol_q;
            ADDR_MASK:     bus_rdata = mask_q;
            ADDR_SENSE_HI: bus_rdata = sense_q[LINES-1:HALF];
            ADDR_SENSE_LO: bus_rdata = sense_q[HALF-1:0];
            ADDR_SRC:      bus_rdata = src_q;
            ADDR_STS:      bus_rdata = sts_q;
            default:       bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_evt_irq_chk.sv
module gpio_evt_irq_chk
    import gpio_evt_pkg::*;
#(
    parameter int LINES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [LINES-1:0]  bus_wdata,
    input logic [LINES-1:0]  src_q,
    input logic [LINES-1:0]  sts_q,
    input logic [LINES-1:0]  mask_q,
    input logic [LINES-1:0]  hit,
    input logic [LINES-1:0]  code_chg,
    input logic              irq_n
);
    // R4
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == (src_q == '0));

    // R3
    masked_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src_q & ~$past(src_q) & $past(mask_q)) == '0));

    // R5
    src_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_SRC) |=>
            (((src_q | sts_q) & $past(bus_wdata) & ~$past(hit)) == '0));

    // R6
    sts_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_STS) |=>
            (((src_q | sts_q) & $past(bus_wdata) & ~$past(hit)) == '0));

    // R7
    code_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_chg != '0) |=> (((src_q | sts_q) & $past(code_chg)) == '0));

    // R2
    src_in_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q & ~sts_q) == '0);
endmodule

bind gpio_evt_irq gpio_evt_irq_chk #(.LINES(LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .src_q     (src_q),
    .sts_q     (sts_q),
    .mask_q    (mask_q),
    .hit       (hit),
    .code_chg  (code_chg),
    .irq_n     (irq_n)
);

// File: tb/gpio_evt_irq_tb.sv
`timescale 1ns/1ps
module gpio_evt_irq_tb;
    import gpio_evt_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] pins;
    logic [2:0] addr;
    logic       we;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq_n;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #4 clk = ~clk;

    gpio_evt_irq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pins),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_n     (irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic arm(input int ln, input logic [1:0] code, input bit masked);
        logic [7:0] hi, lo;
        hi = '0; lo = '0;
        if (ln >= 4) hi[2*(ln-4) +: 2] = code;
        else         lo[2*ln +: 2]     = code;
        wr(ADDR_SENSE_HI, hi);
        wr(ADDR_SENSE_LO, lo);
        wr(ADDR_MASK, masked ? 8'hFF : ~(8'h01 << ln));
        wr(ADDR_STS, 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int idx;
        rst_n = 1'b0; pins = '0; addr = '0; we = 1'b0; wdata = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(ADDR_MASK, v);     chk("R1 mask", v, 8'hFF);
        rd(ADDR_POL, v);      chk("R1 pol", v, 8'h00);
        rd(ADDR_SENSE_HI, v); chk("R1 sense hi", v, 8'h00);
        rd(ADDR_SENSE_LO, v); chk("R1 sense lo", v, 8'h00);
        rd(ADDR_SRC, v);      chk("R1 src", v, 8'h00);
        rd(ADDR_STS, v);      chk("R1 sts", v, 8'h00);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);

        // sweep: every line, code, polarity and pin direction
        idx = 0;
        for (int ln = 0; ln < 8; ln++) begin
            for (int code = 0; code < 4; code++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int d = 0; d < 2; d++) begin
                        bit init, masked, lrise, hitb;
                        logic [7:0] e_sts, e_src;
                        init   = (d == 1);
                        masked = ((ln + code + p + d) % 3) == 0;
                        pins[ln] = init;
                        tick(4);
                        wr(ADDR_POL, 8'(p) << ln);
                        tick(4);
                        arm(ln, 2'(code), masked);
                        rd(ADDR_STS, v); chk("R6 pre-clear sts", v, 8'h00);
                        pins[ln] = ~init;
                        tick(2);
                        rd(ADDR_STS, v); chk("R9 sts not yet set", v, 8'h00);
                        tick(1);
                        lrise = (init == 1'b0) ^ (p == 1);
                        hitb  = (code == 3) || (code == 1 && lrise) || (code == 2 && !lrise);
                        e_sts = hitb ? (8'h01 << ln) : 8'h00;
                        e_src = (hitb && !masked) ? (8'h01 << ln) : 8'h00;
                        rd(ADDR_STS, v); chk("R2 R8 R9 sts", v, e_sts);
                        rd(ADDR_SRC, v); chk("R3 src", v, e_src);
                        chk("R4 irq_n", {7'b0, irq_n}, {7'b0, (e_src == 8'h00)});
                        idx++;
                    end
                end
            end
        end

        pins = '0;
        wr(ADDR_POL, 8'h00);
        tick(4);
        wr(ADDR_STS, 8'hFF);

        // R8 data read through polarity
        pins = 8'hA5;
        wr(ADDR_POL, 8'h0F);
        tick(2);
        rd(ADDR_DATA, v); chk("R8 data", v, 8'hAA);
        pins = '0;
        wr(ADDR_POL, 8'h00);
        tick(4);
        wr(ADDR_STS, 8'hFF);

        // R5 clear through source
        arm(2, EDGE_BOTH, 1'b0);
        pins[2] = 1'b1;
        tick(3);
        rd(ADDR_SRC, v); chk("R5 src set", v, 8'h04);
        chk("R4 irq low", {7'b0, irq_n}, 8'h00);
        wr(ADDR_SRC, 8'h04);
        rd(ADDR_SRC, v); chk("R5 src cleared", v, 8'h00);
        rd(ADDR_STS, v); chk("R5 sts cleared", v, 8'h00);
        chk("R4 irq high", {7'b0, irq_n}, 8'h01);

        // R6 clear through status
        pins[2] = 1'b0;
        tick(3);
        rd(ADDR_SRC, v); chk("R6 src set", v, 8'h04);
        wr(ADDR_STS, 8'h04);
        rd(ADDR_SRC, v); chk("R6 src cleared", v, 8'h00);
        rd(ADDR_STS, v); chk("R6 sts cleared", v, 8'h00);
        chk("R6 irq high", {7'b0, irq_n}, 8'h01);

        // R4 two pending lines
        wr(ADDR_SENSE_HI, 8'h0C);
        wr(ADDR_SENSE_LO, 8'h30);
        wr(ADDR_MASK, 8'h00);
        wr(ADDR_STS, 8'hFF);
        pins[2] = 1'b1; pins[5] = 1'b1;
        tick(3);
        rd(ADDR_SRC, v); chk("R4 src two lines", v, 8'h24);
        wr(ADDR_SRC, 8'h04);
        chk("R4 irq still low", {7'b0, irq_n}, 8'h00);
        wr(ADDR_SRC, 8'h20);
        chk("R4 irq back high", {7'b0, irq_n}, 8'h01);

        // R7 code rewrite
        pins[2] = 1'b0; pins[5] = 1'b0;
        tick(3);
        rd(ADDR_STS, v); chk("R7 sts before", v, 8'h24);
        wr(ADDR_SENSE_HI, 8'h0C);
        rd(ADDR_STS, v); chk("R7 same code keeps", v, 8'h24);
        wr(ADDR_SENSE_HI, 8'h04);
        rd(ADDR_STS, v); chk("R7 changed code clears sts", v, 8'h04);
        rd(ADDR_SRC, v); chk("R7 changed code clears src", v, 8'h04);
        wr(ADDR_STS, 8'hFF);

        // R10 edge and clear on the same clock edge
        pins[2] = 1'b1;
        tick(3);
        rd(ADDR_STS, v); chk("R10 sts set", v, 8'h04);
        pins[2] = 1'b0;
        tick(2);
        wr(ADDR_STS, 8'h04);
        rd(ADDR_STS, v); chk("R10 sts kept", v, 8'h04);
        rd(ADDR_SRC, v); chk("R10 src kept", v, 8'h04);
        wr(ADDR_STS, 8'h04);
        rd(ADDR_STS, v); chk("R10 later clear", v, 8'h00);
        chk("R10 irq high", {7'b0, irq_n}, 8'h01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule